// File: doc/BRIEF.md
# Load-Store Decode and Byte-Lane Unit

This block turns one 32-bit load or store instruction word into a request on a simple data memory port. Instruction bits are numbered big-endian, so bit 0 of the word is the MSB (vector bit 31). The unit decodes the register and immediate forms, computes the effective address, places store data on the correct byte lanes with matching byte enables, and on the return path picks the addressed lane out of the read word, zero-extending byte and halfword loads before handing the value back for register writeback.

Register forms carry an 11-bit function field. It selects one of four variants: the plain access, a byte-reversed access, an extended-address access that presents a 64-bit address, and an exclusive word store. The exclusive store is gated by a one-bit reservation flag. A separate input sets that flag, and every exclusive store clears it. Anything the unit does not recognise raises a one-cycle illegal flag and touches no memory.

The request is registered one cycle after issue. The memory is expected to return read data in the cycle the request is visible. The writeback value is registered one cycle after that.

Top module: `ldst_lane_unit`

## Requirements
- R1: The opcode is instruction vector bits 31:26, the destination index is 25:21, the function field is 10:0 and the immediate is 15:0. Register-form loads use opcodes 110000 (byte), 110001 (halfword) and 110010 (word). Register-form stores use 110100 (byte), 110101 (halfword) and 110110 (word). Immediate loads use 111000, 111001 and 111010, and immediate stores use 111100, 111101 and 111110, in the same size order.
- R2: Plain, reversed and exclusive register forms address Ra+Rb. Immediate forms address Ra plus the sign-extended 16-bit immediate. For all of these, mem_addr bits 63:32 are zero.
- R3: Function field 00010000000 (0x080) selects the extended access, whose mem_addr is {Ra, Rb}. The lane offset is taken from Rb.
- R4: A byte store with address offset k (low two bits) sets only mem_be[3-k], so offset 0 drives bits 31:24. Rd bits 7:0 are replicated in all four lanes of mem_wdata.
- R5: A halfword store sets mem_be to 1100 when address bit 1 is 0 and to 0011 when it is 1. Rd bits 15:0 are replicated in both halves. A word store sets mem_be to 1111 and writes Rd unchanged.
- R6: Function field 01000000000 (0x200) selects byte reversal. A reversed halfword store writes {Rd[7:0],Rd[15:8]}, a reversed word store writes Rd with its four bytes in reverse order, and a reversed byte store is identical to a plain one.
- R7: A byte load returns the addressed lane of mem_rdata zero-extended to 32 bits. A halfword load returns the addressed half zero-extended. A word load returns mem_rdata whole.
- R8: Reversed halfword and word loads return the selected half or word with its bytes swapped, then zero-extended.
- R9: Reset and every exclusive store clear the reservation flag, and a set_resv pulse sets it. An exclusive store (function 10000000000 = 0x400, word-store opcode only) raises mem_we only while the flag is set.
- R10: An issued word with an unknown opcode, an unknown function field, or the exclusive variant on anything other than a register word store raises illegal for one cycle. Such a word drives no mem_we, no mem_re and no later wb_en.
- R11: Request outputs appear one cycle after issue, with mem_re high for loads and mem_we high for stores. For a load, wb_en, wb_rd (the Rd field) and wb_data appear one cycle after mem_re. Stores produce no wb_en.
- R12: In a cycle after no issue, mem_we, mem_re and illegal are low and mem_be is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| ra_val | input | 32 | Value of the Ra operand |
| rb_val | input | 32 | Value of the Rb operand |
| rd_val | input | 32 | Value of Rd (store data) |
| set_resv | input | 1 | Sets the reservation flag |
| mem_rdata | input | 32 | Read data, valid in the cycle mem_re is high |
| mem_addr | output | 64 | Byte address of the access |
| mem_be | output | 4 | Byte enables, bit 3 for bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| illegal | output | 1 | Unrecognised instruction was issued |
| wb_en | output | 1 | Writeback value is valid |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 32 | Value to write back |

## Verification
The bench walks byte stores across all four offsets and halfword stores across both halves. A lane order that is flipped to little-endian shows up as enables and data on the opposite end of the word. It loads from a read word with its top bit set, so a sign-extending or mis-shifted load leaves ones or the wrong byte in the upper bits. It issues an exclusive store straight after reset, after a set pulse, and twice in a row. A flag that resets high, or that is not cleared by the first store, produces a stray write. Unknown opcodes and misused function fields are issued to catch a decoder that still strobes memory or writes back.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    VAR_PLAIN = 2'd0,
    VAR_REV   = 2'd1,
    VAR_EXT   = 2'd2,
    VAR_EXCL  = 2'd3
  } acc_var_e;

  typedef struct packed {
    logic      legal;
    logic      is_load;
    logic      is_store;
    logic      imm_form;
    acc_size_e size;
    acc_var_e  variant;
    logic [4:0]  rd_idx;
    logic [15:0] imm;
  } acc_dec_t;

  localparam logic [10:0] FN_PLAIN = 11'h000;
  localparam logic [10:0] FN_REV   = 11'h200;
  localparam logic [10:0] FN_EXT   = 11'h080;
  localparam logic [10:0] FN_EXCL  = 11'h400;

endpackage

// File: rtl/ldst_decoder.sv
module ldst_decoder
  import ldst_pkg::*;
(
  input  logic [31:0] instr,
  output acc_dec_t    dec
);

  logic [5:0]  opc;
  logic [10:0] fn;
  logic        reg_form;
  logic        unused_ra_field;

  assign opc = instr[31:26];
  assign fn  = instr[10:0];
  assign unused_ra_field = ^instr[20:16];

  always_comb begin
    dec          = '0;
    dec.size     = SZ_WORD;
    dec.variant  = VAR_PLAIN;
    dec.rd_idx   = instr[25:21];
    dec.imm      = instr[15:0];
    reg_form     = 1'b0;
    unique case (opc)
      6'b110000: begin dec.is_load  = 1'b1; dec.size = SZ_BYTE; reg_form = 1'b1; end
      6'b110001: begin dec.is_load  = 1'b1; dec.size = SZ_HALF; reg_form = 1'b1; end
      6'b110010: begin dec.is_load  = 1'b1; dec.size = SZ_WORD; reg_form = 1'b1; end
      6'b110100: begin dec.is_store = 1'b1; dec.size = SZ_BYTE; reg_form = 1'b1; end
      6'b110101: begin dec.is_store = 1'b1; dec.size = SZ_HALF; reg_form = 1'b1; end
      6'b110110: begin dec.is_store = 1'b1; dec.size = SZ_WORD; reg_form = 1'b1; end
      6'b111000: begin dec.is_load  = 1'b1; dec.size = SZ_BYTE; dec.imm_form = 1'b1; end
      6'b111001: begin dec.is_load  = 1'b1; dec.size = SZ_HALF; dec.imm_form = 1'b1; end
      6'b111010: begin dec.is_load  = 1'b1; dec.size = SZ_WORD; dec.imm_form = 1'b1; end
      6'b111100: begin dec.is_store = 1'b1; dec.size = SZ_BYTE; dec.imm_form = 1'b1; end
      6'b111101: begin dec.is_store = 1'b1; dec.size = SZ_HALF; dec.imm_form = 1'b1; end
      6'b111110: begin dec.is_store = 1'b1; dec.size = SZ_WORD; dec.imm_form = 1'b1; end
      default: ;
    endcase

    if (dec.imm_form) begin
      dec.legal = 1'b1;
    end else if (reg_form) begin
      unique case (fn)
        FN_PLAIN: begin dec.legal = 1'b1; dec.variant = VAR_PLAIN; end
        FN_REV:   begin dec.legal = 1'b1; dec.variant = VAR_REV;   end
        FN_EXT:   begin dec.legal = 1'b1; dec.variant = VAR_EXT;   end
        FN_EXCL:  begin
          dec.variant = VAR_EXCL;
          dec.legal   = dec.is_store && (dec.size == SZ_WORD);
        end
        default: ;
      endcase
    end

    if (!dec.legal) begin
      dec.is_load  = 1'b0;
      dec.is_store = 1'b0;
    end
  end

  always_comb begin
    assert_illegal_no_access_R10: assert (dec.legal || (!dec.is_load && !dec.is_store));
    assert_one_kind_R1: assert ($onehot0({dec.is_load, dec.is_store}));
  end

endmodule

// File: rtl/ldst_store_lane.sv
module ldst_store_lane
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_size_e          size,
  input  logic               rev,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  rd_val,
  output logic [NBYTES-1:0]  be,
  output logic [DATA_W-1:0]  wdata
);

  logic [15:0]       half_src;
  logic [DATA_W-1:0] word_swap;
  logic [DATA_W-1:0] word_src;

  assign half_src = rev ? {rd_val[7:0], rd_val[15:8]} : rd_val[15:0];

  for (genvar j = 0; j < NBYTES; j++) begin : g_swap
    assign word_swap[8*j +: 8] = rd_val[DATA_W-1-8*j -: 8];
  end

  assign word_src = rev ? word_swap : rd_val;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    logic [7:0] lane_d;
    logic       lane_e;
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          lane_d = rd_val[7:0];
          lane_e = (off == OFF_W'(i));
        end
        SZ_HALF: begin
          lane_d = (i % 2 == 0) ? half_src[15:8] : half_src[7:0];
          lane_e = (off[OFF_W-1:1] == (OFF_W-1)'(i / 2));
        end
        default: begin
          lane_d = word_src[HI -: 8];
          lane_e = 1'b1;
        end
      endcase
    end
    assign wdata[HI -: 8]     = lane_d;
    assign be[NBYTES-1-i]     = lane_e;
  end

endmodule

// File: rtl/ldst_load_lane.sv
module ldst_load_lane
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_size_e          size,
  input  logic               rev,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  result
);

  logic [7:0]        byte_v;
  logic [15:0]       half_v;
  logic [DATA_W-1:0] word_swap;

  for (genvar j = 0; j < NBYTES; j++) begin : g_swap
    assign word_swap[8*j +: 8] = rdata[DATA_W-1-8*j -: 8];
  end

  always_comb begin
    byte_v = '0;
    half_v = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (off == OFF_W'(i)) byte_v = rdata[DATA_W-1-8*i -: 8];
    end
    for (int k = 0; k < NBYTES / 2; k++) begin
      if (off[OFF_W-1:1] == (OFF_W-1)'(k)) half_v = rdata[DATA_W-1-16*k -: 16];
    end
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){1'b0}}, byte_v};
      SZ_HALF: result = rev ? {{(DATA_W-16){1'b0}}, half_v[7:0], half_v[15:8]}
                            : {{(DATA_W-16){1'b0}}, half_v};
      default: result = rev ? word_swap : rdata;
    endcase
  end

endmodule

// File: rtl/ldst_resv.sv
module ldst_resv (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clear_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst)          flag_o <= 1'b0;
    else if (clear_i) flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
  end

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !flag_o);
  assert_set_takes_R9: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clear_i) |=> flag_o);

endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES),
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] ra_val,
  input  logic [DATA_W-1:0] rb_val,
  input  logic [DATA_W-1:0] rd_val,
  input  logic              set_resv,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBYTES-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              illegal,
  output logic              wb_en,
  output logic [4:0]        wb_rd,
  output logic [DATA_W-1:0] wb_data
);

  acc_dec_t          dec;
  logic              go, is_excl, is_rev, resv_flag;
  logic              we_next, re_next;
  logic [ADDR_W-1:0] ea;
  logic [OFF_W-1:0]  off;
  logic [NBYTES-1:0] st_be;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] ld_result;

  acc_size_e         size_q;
  logic              rev_q, ext_q;
  logic [OFF_W-1:0]  off_q;
  logic [4:0]        rd_q;

  ldst_decoder u_dec (.instr(instr), .dec(dec));

  assign go      = issue_valid && dec.legal;
  assign is_excl = (dec.variant == VAR_EXCL);
  assign is_rev  = (dec.variant == VAR_REV);

  ldst_resv u_resv (
    .clk(clk), .rst(rst), .set_i(set_resv),
    .clear_i(go && is_excl), .flag_o(resv_flag)
  );

  always_comb begin
    if (dec.imm_form)
      ea = {{DATA_W{1'b0}}, ra_val + {{(DATA_W-16){dec.imm[15]}}, dec.imm}};
    else if (dec.variant == VAR_EXT)
      ea = {ra_val, rb_val};
    else
      ea = {{DATA_W{1'b0}}, ra_val + rb_val};
  end

  assign off = ea[OFF_W-1:0];

  ldst_store_lane #(.DATA_W(DATA_W)) u_st (
    .size(dec.size), .rev(is_rev), .off(off), .rd_val(rd_val),
    .be(st_be), .wdata(st_wdata)
  );

  assign we_next = go && dec.is_store && (!is_excl || resv_flag);
  assign re_next = go && dec.is_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      illegal   <= 1'b0;
      size_q    <= SZ_WORD;
      rev_q     <= 1'b0;
      ext_q     <= 1'b0;
      off_q     <= '0;
      rd_q      <= '0;
    end else begin
      mem_addr  <= ea;
      mem_be    <= (we_next || re_next) ? st_be : '0;
      mem_wdata <= st_wdata;
      mem_we    <= we_next;
      mem_re    <= re_next;
      illegal   <= issue_valid && !dec.legal;
      size_q    <= dec.size;
      rev_q     <= is_rev;
      ext_q     <= (dec.variant == VAR_EXT) && !dec.imm_form;
      off_q     <= off;
      rd_q      <= dec.rd_idx;
    end
  end

  ldst_load_lane #(.DATA_W(DATA_W)) u_ld (
    .size(size_q), .rev(rev_q), .off(off_q), .rdata(mem_rdata),
    .result(ld_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_rd   <= '0;
      wb_data <= '0;
    end else begin
      wb_en <= mem_re;
      if (mem_re) begin
        wb_rd   <= rd_q;
        wb_data <= ld_result;
      end
    end
  end

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!mem_we && !mem_re));
  assert_wb_after_read_R11: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> wb_en);
  assert_no_wb_without_read_R11: assert property (@(posedge clk) disable iff (rst)
    !mem_re |=> !wb_en);
  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && size_q == SZ_BYTE) |-> $countones(mem_be) == 1);
  assert_upper_addr_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((mem_we || mem_re) && !ext_q) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));
  assert_excl_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (go && is_excl && !resv_flag) |=> !mem_we);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!mem_we && !mem_re && !illegal && mem_be == '0));

endmodule

// File: tb/test_ldst_lane_unit.sv
module test_ldst_lane_unit;

  localparam logic [31:0] LD_PAT = 32'h8A5B_C3D4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0, ra_val = '0, rb_val = '0, rd_val = '0;
  logic        set_resv = 1'b0;
  logic [31:0] mem_rdata;
  logic [63:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, wb_data;
  logic        mem_we, mem_re, illegal, wb_en;
  logic [4:0]  wb_rd;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem_re ? LD_PAT : 32'h0;

  ldst_lane_unit i_ldst_lane_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .ra_val(ra_val), .rb_val(rb_val), .rd_val(rd_val), .set_resv(set_resv),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .illegal(illegal), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  function automatic logic [31:0] rform(input logic [5:0] op, input logic [4:0] rd,
                                        input logic [10:0] fn);
    return {op, rd, 5'd1, 5'd2, fn};
  endfunction

  function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] rd,
                                        input logic [15:0] imm);
    return {op, rd, 5'd1, imm};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one issue cycle; returns at the negedge where the request is visible.
  task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] d);
    @(negedge clk);
    instr = ins; ra_val = a; rb_val = b; rd_val = d; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0; instr = '0;
  endtask

  task automatic t_reset;
    chk("R12 reset we", {63'd0, mem_we}, 64'd0);
    chk("R12 reset re", {63'd0, mem_re}, 64'd0);
    chk("R10 reset illegal", {63'd0, illegal}, 64'd0);
    chk("R11 reset wb_en", {63'd0, wb_en}, 64'd0);
    chk("R12 reset be", {60'd0, mem_be}, 64'd0);
  endtask

  task automatic t_byte_stores;
    for (int k = 0; k < 4; k++) begin
      issue(rform(6'b110100, 5'd3, 11'h000), 32'h100, k, 32'hDEAD_BEA5);
      chk("R4 sb we", {63'd0, mem_we}, 64'd1);
      chk("R2 sb addr", mem_addr, 64'h100 + k);
      chk("R4 sb be", {60'd0, mem_be}, {60'd0, 4'b1000 >> k});
      chk("R4 sb wdata", {32'd0, mem_wdata}, 64'hA5A5_A5A5);
    end
    @(negedge clk);
    chk("R11 store no wb", {63'd0, wb_en}, 64'd0);
  endtask

  task automatic t_half_word_stores;
    issue(rform(6'b110101, 5'd3, 11'h000), 32'h200, 32'h0, 32'h1122_3344);
    chk("R5 sh lo be", {60'd0, mem_be}, 64'b1100);
    chk("R5 sh wdata", {32'd0, mem_wdata}, 64'h3344_3344);
    issue(iform(6'b111101, 5'd3, 16'h0002), 32'h200, 32'h0, 32'h1122_3344);
    chk("R5 shi hi be", {60'd0, mem_be}, 64'b0011);
    chk("R2 shi addr", mem_addr, 64'h202);
    issue(rform(6'b110110, 5'd3, 11'h000), 32'h300, 32'h4, 32'h1122_3344);
    chk("R5 sw be", {60'd0, mem_be}, 64'b1111);
    chk("R5 sw wdata", {32'd0, mem_wdata}, 64'h1122_3344);
  endtask

  task automatic t_imm_and_ext_addr;
    issue(iform(6'b111110, 5'd4, 16'hFFFC), 32'h1000, 32'h0, 32'h0);
    chk("R2 swi neg imm addr", mem_addr, 64'h0FFC);
    issue(iform(6'b111110, 5'd4, 16'h0010), 32'hFFFF_FFF8, 32'h0, 32'h0);
    chk("R2 swi wrap addr", mem_addr, 64'h0000_0000_0000_0008);
    issue(rform(6'b110110, 5'd4, 11'h080), 32'h1234_5678, 32'h9ABC_DEF4, 32'h55);
    chk("R3 ext addr", mem_addr, 64'h1234_5678_9ABC_DEF4);
    chk("R3 ext we", {63'd0, mem_we}, 64'd1);
    issue(rform(6'b110100, 5'd4, 11'h080), 32'h1, 32'h3, 32'h77);
    chk("R3 ext byte lane from Rb", {60'd0, mem_be}, 64'b0001);
  endtask

  task automatic t_reversed_stores;
    issue(rform(6'b110101, 5'd3, 11'h200), 32'h0, 32'h2, 32'h1122_3344);
    chk("R6 shr be", {60'd0, mem_be}, 64'b0011);
    chk("R6 shr wdata", {32'd0, mem_wdata}, 64'h4433_4433);
    issue(rform(6'b110110, 5'd3, 11'h200), 32'h0, 32'h0, 32'h1122_3344);
    chk("R6 swr wdata", {32'd0, mem_wdata}, 64'h4433_2211);
    issue(rform(6'b110100, 5'd3, 11'h200), 32'h0, 32'h1, 32'h0000_00AB);
    chk("R6 sbr be", {60'd0, mem_be}, 64'b0100);
    chk("R6 sbr wdata", {32'd0, mem_wdata}, 64'hABAB_ABAB);
  endtask

  task automatic load_and_check(input string tag, input logic [31:0] ins,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [4:0] rd, input logic [31:0] exp);
    issue(ins, a, b, 32'h0);
    chk({tag, " re"}, {63'd0, mem_re}, 64'd1);
    chk({tag, " we"}, {63'd0, mem_we}, 64'd0);
    @(negedge clk);
    chk({tag, " wb_en"}, {63'd0, wb_en}, 64'd1);
    chk({tag, " wb_rd"}, {59'd0, wb_rd}, {59'd0, rd});
    chk({tag, " wb_data"}, {32'd0, wb_data}, {32'd0, exp});
  endtask

  task automatic t_loads;
    load_and_check("R7 lbui off1", iform(6'b111000, 5'd9, 16'h0001), 32'h40, 0, 5'd9, 32'h5B);
    load_and_check("R7 lbui off3", iform(6'b111000, 5'd10, 16'h0003), 32'h40, 0, 5'd10, 32'hD4);
    load_and_check("R7 lbu off0", rform(6'b110000, 5'd11, 11'h000), 32'h40, 0, 5'd11, 32'h8A);
    load_and_check("R7 lhui off2", iform(6'b111001, 5'd12, 16'h0002), 32'h40, 0, 5'd12, 32'hC3D4);
    load_and_check("R7 lhu off0", rform(6'b110001, 5'd13, 11'h000), 32'h40, 0, 5'd13, 32'h8A5B);
    load_and_check("R7 lwi", iform(6'b111010, 5'd14, 16'h0000), 32'h40, 0, 5'd14, LD_PAT);
    load_and_check("R8 lhur off0", rform(6'b110001, 5'd15, 11'h200), 32'h40, 0, 5'd15, 32'h5B8A);
    load_and_check("R8 lwr", rform(6'b110010, 5'd16, 11'h200), 32'h40, 0, 5'd16, 32'hD4C3_5B8A);
  endtask

  task automatic t_exclusive;
    logic [31:0] swx;
    swx = rform(6'b110110, 5'd5, 11'h400);
    issue(swx, 32'h80, 32'h0, 32'hCAFE);
    chk("R9 swx after reset no write", {63'd0, mem_we}, 64'd0);
    chk("R9 swx legal", {63'd0, illegal}, 64'd0);
    @(negedge clk); set_resv = 1'b1;
    @(negedge clk); set_resv = 1'b0;
    issue(swx, 32'h80, 32'h0, 32'hCAFE);
    chk("R9 swx with flag writes", {63'd0, mem_we}, 64'd1);
    chk("R9 swx wdata", {32'd0, mem_wdata}, 64'hCAFE);
    issue(swx, 32'h80, 32'h0, 32'hCAFE);
    chk("R9 second swx no write", {63'd0, mem_we}, 64'd0);
  endtask

  task automatic t_illegal;
    issue(32'h0000_0000, 32'h10, 32'h0, 32'h0);
    chk("R10 bad opcode illegal", {63'd0, illegal}, 64'd1);
    chk("R10 bad opcode no we", {63'd0, mem_we}, 64'd0);
    chk("R10 bad opcode no re", {63'd0, mem_re}, 64'd0);
    issue(rform(6'b110100, 5'd3, 11'h400), 32'h10, 32'h0, 32'h0);
    chk("R10 excl on byte illegal", {63'd0, illegal}, 64'd1);
    chk("R10 excl on byte no we", {63'd0, mem_we}, 64'd0);
    issue(rform(6'b110010, 5'd3, 11'h001), 32'h10, 32'h0, 32'h0);
    chk("R10 bad fn illegal", {63'd0, illegal}, 64'd1);
    chk("R10 bad fn no re", {63'd0, mem_re}, 64'd0);
    @(negedge clk);
    chk("R10 no wb after illegal", {63'd0, wb_en}, 64'd0);
    chk("R12 illegal one cycle", {63'd0, illegal}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_exclusive();
    t_byte_stores();
    t_half_word_stores();
    t_imm_and_ext_addr();
    t_reversed_stores();
    t_loads();
    t_illegal();
    @(negedge clk);
    chk("R12 idle no we", {63'd0, mem_we}, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule